// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block sits between a set of peripheral interrupt source flags and a CPU. Sixteen source flags, each gated by its own enable, are folded onto ten vector slots; a slot requests whenever any of its enabled sources is set. Every slot carries a one-bit level select. The select picks between the two levels that slot may use: the first two slots choose between the top level and the low level, and the other eight choose between the high level and the low level.

Each cycle the arbiter picks one winning slot and presents it to the CPU as a registered request with a vector address and a level. A request is only presented if its level is strictly above the level of the interrupt now being serviced. Among the candidates, the highest level wins, and among equal levels the lowest slot index (smallest address) wins. The CPU takes a presented request by pulsing `ack`; the accepted level is pushed onto a small service-level stack. A `reti` pulse pops the stack back to the level that was interrupted. The request output acts as a valid signal and `ack` as its ready. The request is re-evaluated every cycle and is never held for the CPU. It is dropped for the cycle after an accepted `ack`, and an `ack` seen while no request is presented has no effect. Clearing source flags is left to the peripherals.

Top module: `irq_arb_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `irq_req` is 0 and `cur_level` is 0 (idle).
- R2: Source to slot mapping: source 0 to slot 0, 1 to slot 1, sources 2..4 to slot 2, 5..6 to slot 3, 7..8 to slot 4, 9..10 to slot 5, 11 to slot 6, 12 to slot 7, 13..15 to slot 8; slot 9 has no source. A slot requests when any source mapped to it has both `src_flag` and `src_en` set.
- R3: Level codes are 0 idle, 1 low, 2 high, 3 top. `lvl_sel[v]`=0 gives level 1; `lvl_sel[v]`=1 gives level 3 for slots 0 and 1 and level 2 for slots 2..9. `irq_level` reports the winner's level.
- R4: Among requesting slots, the one with the highest level wins.
- R5: Among winning candidates of equal level, the lowest slot index wins.
- R6: The vector address of slot v is 0x03 + 8*v (0x03, 0x0B, ... 0x4B).
- R7: `irq_req`, `irq_vec_addr` and `irq_level` are registered: they reflect the inputs and `cur_level` of the previous cycle.
- R8: A slot whose level is less than or equal to `cur_level` is not presented; with `cur_level`=0 any level is presented.
- R9: `ack` while `irq_req` is 1 pushes `irq_level`: `cur_level` takes that value in the next cycle, and `irq_req` is 0 in the next cycle.
- R10: `reti` pops the stack, so `cur_level` returns to the interrupted level, or to 0 if none; `reti` with an empty stack has no effect.
- R11: `ack` while `irq_req` is 0 has no effect on `cur_level` or on the outputs.
- R12: Accepted `ack` and `reti` in the same cycle replace the top stack entry with `irq_level` without changing the depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_flag | input | 16 | Interrupt source flags |
| src_en | input | 16 | Per-source enables |
| lvl_sel | input | 10 | Per-slot level select (see R3) |
| ack | input | 1 | CPU accepts the presented request |
| reti | input | 1 | Return from the interrupt being serviced |
| irq_req | output | 1 | Request presented to the CPU |
| irq_vec_addr | output | 8 | Vector address of the presented request |
| irq_level | output | 2 | Level of the presented request |
| cur_level | output | 2 | Level now being serviced (0 idle) |

## Verification
Single enabled sources on different slots confirm the mapping and address arithmetic, and a set flag with its enable cleared confirms gating. Paired requests at equal level tell the lowest-index rule apart from a highest-index scan. Mixed-level pairs, including a top-level slot against a high-level one, tell level ranking from index ranking. Directed nesting sequences (accept, blocked equal level, nested higher level, pops, a return at idle, an unmatched acknowledge, and a simultaneous acknowledge and return) separate push, pop and replace. Long random runs with sparse flags and random acknowledge and return pulses then compare every cycle against a bench model.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_IDLE = 2'd0;
  localparam lvl_t LVL_LO   = 2'd1;
  localparam lvl_t LVL_HI   = 2'd2;
  localparam lvl_t LVL_TOP  = 2'd3;
endpackage

// File: rtl/irq_src_merge.sv
module irq_src_merge #(
  parameter int NSRC   = 16,
  parameter int NVEC   = 10,
  parameter int VIDX_W = 4,
  parameter logic [NSRC*VIDX_W-1:0] SRC_MAP = '0
) (
  input  logic [NSRC-1:0] flag,
  input  logic [NSRC-1:0] en,
  output logic [NVEC-1:0] vreq
);
  // Each slot ORs the enabled flags whose map entry names it (R2)
  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    logic [NSRC-1:0] hit;
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign hit[s] = (SRC_MAP[s*VIDX_W +: VIDX_W] == VIDX_W'(v)) && flag[s] && en[s];
    end
    assign vreq[v] = |hit;
  end
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_arb_pkg::*;
#(
  parameter int NVEC     = 10,
  parameter int TOP_VECS = 2
) (
  input  logic [NVEC-1:0]      sel,
  output logic [NVEC-1:0][1:0] vlvl
);
  // One select bit per slot; the slot position fixes which pair is legal (R3)
  for (genvar v = 0; v < NVEC; v++) begin : g_lvl
    if (v < TOP_VECS) begin : g_top
      assign vlvl[v] = sel[v] ? LVL_TOP : LVL_LO;
    end else begin : g_hi
      assign vlvl[v] = sel[v] ? LVL_HI : LVL_LO;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int NVEC       = 10,
  parameter int ADDR_W     = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic [NVEC-1:0]      vreq,
  input  logic [NVEC-1:0][1:0] vlvl,
  input  lvl_t                 cur,
  output logic                 valid,
  output logic [ADDR_W-1:0]    addr,
  output lvl_t                 lvl
);
  // Ascending scan with strict compare: higher level replaces, equal keeps lower index
  always_comb begin
    valid = 1'b0;
    lvl   = LVL_IDLE;
    addr  = '0;
    for (int v = 0; v < NVEC; v++) begin
      if (vreq[v] && (vlvl[v] > cur) && (vlvl[v] > lvl)) begin
        valid = 1'b1;
        lvl   = vlvl[v];
        addr  = ADDR_W'(VEC_BASE + v * VEC_STRIDE);
      end
    end
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  lvl_t push_lvl,
  output lvl_t top_lvl
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam logic [SPW-1:0] SP_MAX = SPW'(DEPTH);

  lvl_t           stk [DEPTH];
  logic [SPW-1:0] sp;
  logic           nonempty;

  assign nonempty = (sp != '0);
  assign top_lvl  = nonempty ? stk[sp - 1'b1] : LVL_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= LVL_IDLE;
    end else if (push && pop && nonempty) begin
      stk[sp - 1'b1] <= push_lvl;
    end else if (push && (sp != SP_MAX)) begin
      stk[sp] <= push_lvl;
      sp      <= sp + 1'b1;
    end else if (pop && nonempty) begin
      sp <= sp - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !(pop && nonempty)) |-> (sp != SP_MAX)); // R9
  AST_IDLE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !nonempty) |=> (sp == '0)); // R10
endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_arb_pkg::*;
#(
  parameter int NSRC       = 16,
  parameter int NVEC       = 10,
  parameter int TOP_VECS   = 2,
  parameter int ADDR_W     = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int STK_DEPTH  = 3,
  parameter logic [NSRC*$clog2(NVEC)-1:0] SRC_MAP = 64'h8887_6554_4332_2210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_flag,
  input  logic [NSRC-1:0]   src_en,
  input  logic [NVEC-1:0]   lvl_sel,
  input  logic              ack,
  input  logic              reti,
  output logic              irq_req,
  output logic [ADDR_W-1:0] irq_vec_addr,
  output logic [1:0]        irq_level,
  output logic [1:0]        cur_level
);
  localparam int VIDX_W = $clog2(NVEC);

  logic [NVEC-1:0]      vreq;
  logic [NVEC-1:0][1:0] vlvl;
  logic                 pick_valid;
  logic [ADDR_W-1:0]    pick_addr;
  lvl_t                 pick_lvl;
  lvl_t                 top_lvl;
  logic                 req_q;
  logic [ADDR_W-1:0]    addr_q;
  lvl_t                 lvl_q;
  logic                 ack_ok;

  irq_src_merge #(.NSRC(NSRC), .NVEC(NVEC), .VIDX_W(VIDX_W), .SRC_MAP(SRC_MAP)) u_merge (
    .flag (src_flag),
    .en   (src_en),
    .vreq (vreq)
  );

  irq_level_map #(.NVEC(NVEC), .TOP_VECS(TOP_VECS)) u_lmap (
    .sel  (lvl_sel),
    .vlvl (vlvl)
  );

  irq_pick #(.NVEC(NVEC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_pick (
    .vreq  (vreq),
    .vlvl  (vlvl),
    .cur   (top_lvl),
    .valid (pick_valid),
    .addr  (pick_addr),
    .lvl   (pick_lvl)
  );

  assign ack_ok = ack && req_q;

  irq_level_stack #(.DEPTH(STK_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack_ok),
    .pop      (reti),
    .push_lvl (lvl_q),
    .top_lvl  (top_lvl)
  );

  // Registered presentation; an accepted request is withdrawn for one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      lvl_q  <= LVL_IDLE;
    end else begin
      req_q  <= pick_valid && !ack_ok;
      addr_q <= pick_addr;
      lvl_q  <= pick_lvl;
    end
  end

  assign irq_req      = req_q;
  assign irq_vec_addr = addr_q;
  assign irq_level    = lvl_q;
  assign cur_level    = top_lvl;

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |=> !irq_req); // R9
  AST_ACK_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok && !reti) |=> (cur_level == $past(irq_level))); // R9
  AST_REQ_ABOVE_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level > cur_level)); // R8
  AST_ADDR_ON_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (((int'(irq_vec_addr) - VEC_BASE) % VEC_STRIDE) == 0)); // R6
  AST_QUIET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_ok && !reti) |=> $stable(cur_level)); // R11
endmodule

// File: tb/irq_arb_top_bench.sv
module irq_arb_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_flag, src_en;
  logic [9:0]  lvl_sel;
  logic        ack, reti;
  logic        irq_req;
  logic [7:0]  irq_vec_addr;
  logic [1:0]  irq_level, cur_level;

  always #4 clk = ~clk;

  irq_arb_top u_irq_arb_top (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
    .lvl_sel(lvl_sel), .ack(ack), .reti(reti), .irq_req(irq_req),
    .irq_vec_addr(irq_vec_addr), .irq_level(irq_level), .cur_level(cur_level)
  );

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  int   m_sp;
  logic [1:0] m_stk [3];
  logic       m_req;
  logic [7:0] m_addr;
  logic [1:0] m_lvl;

  function automatic int vec_of(int s);
    if (s == 0) return 0;
    if (s == 1) return 1;
    if (s <= 4) return 2;
    if (s <= 6) return 3;
    if (s <= 8) return 4;
    if (s <= 10) return 5;
    if (s == 11) return 6;
    if (s == 12) return 7;
    return 8;
  endfunction

  function automatic logic [1:0] lvl_of(int v, logic [9:0] sel);
    if (!sel[v]) return 2'd1;
    return (v < 2) ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [1:0] m_cur();
    return (m_sp == 0) ? 2'd0 : m_stk[m_sp-1];
  endfunction

  task automatic step(input logic [15:0] f, input logic [15:0] e, input logic [9:0] sel,
                      input logic a, input logic r, input string tag);
    logic       ackeff, nreq, hit;
    logic [7:0] naddr;
    logic [1:0] nlvl, lv;
    src_flag = f; src_en = e; lvl_sel = sel; ack = a; reti = r;
    ackeff = a && m_req;
    nreq = 1'b0; naddr = 8'd0; nlvl = 2'd0;
    for (int v = 0; v < 10; v++) begin
      hit = 1'b0;
      for (int s = 0; s < 16; s++) if (vec_of(s) == v && f[s] && e[s]) hit = 1'b1;
      lv = lvl_of(v, sel);
      if (hit && lv > m_cur() && lv > nlvl) begin
        nreq = 1'b1; nlvl = lv; naddr = 8'(3 + 8 * v);
      end
    end
    if (ackeff) nreq = 1'b0;
    if (ackeff && r && m_sp > 0) m_stk[m_sp-1] = m_lvl;
    else if (ackeff && m_sp < 3) begin m_stk[m_sp] = m_lvl; m_sp++; end
    else if (r && m_sp > 0) m_sp--;
    m_req = nreq; m_addr = naddr; m_lvl = nlvl;
    @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (irq_req !== m_req || cur_level !== m_cur() ||
        (m_req && (irq_vec_addr !== m_addr || irq_level !== m_lvl))) begin
      n_bad++;
      $display("FAIL %s: req=%0b addr=%h lvl=%0d cur=%0d expected req=%0b addr=%h lvl=%0d cur=%0d",
               tag, irq_req, irq_vec_addr, irq_level, cur_level, m_req, m_addr, m_lvl, m_cur());
    end
  endtask

  task automatic expect_out(input logic rq, input logic [7:0] ad, input logic [1:0] lv,
                            input logic [1:0] cu, input string tag);
    n_chk++;
    if (irq_req !== rq || cur_level !== cu || (rq && (irq_vec_addr !== ad || irq_level !== lv))) begin
      n_bad++;
      $display("FAIL %s: req=%0b addr=%h lvl=%0d cur=%0d expected req=%0b addr=%h lvl=%0d cur=%0d",
               tag, irq_req, irq_vec_addr, irq_level, cur_level, rq, ad, lv, cu);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run still busy, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; src_flag = '0; src_en = '0; lvl_sel = '0; ack = 1'b0; reti = 1'b0;
    m_sp = 0; m_req = 1'b0; m_addr = '0; m_lvl = '0;
    for (int i = 0; i < 3; i++) m_stk[i] = 2'd0;
    repeat (3) @(negedge clk);
    expect_out(1'b0, 8'h00, 2'd0, 2'd0, "R1");
    rst_n = 1'b1;
    step(16'h0000, 16'h0000, 10'h000, 1'b0, 1'b0, "R1");
    expect_out(1'b0, 8'h00, 2'd0, 2'd0, "R1");

    step(16'h0008, 16'h0008, 10'h000, 1'b0, 1'b0, "R2");
    expect_out(1'b1, 8'h13, 2'd1, 2'd0, "R6");
    step(16'h0008, 16'h0000, 10'h000, 1'b0, 1'b0, "R2");
    expect_out(1'b0, 8'h00, 2'd0, 2'd0, "R2");
    step(16'h8000, 16'hFFFF, 10'h000, 1'b0, 1'b0, "R2");
    expect_out(1'b1, 8'h43, 2'd1, 2'd0, "R6");
    step(16'h0820, 16'hFFFF, 10'h000, 1'b0, 1'b0, "R5");
    expect_out(1'b1, 8'h1B, 2'd1, 2'd0, "R5");
    step(16'h1001, 16'hFFFF, 10'h080, 1'b0, 1'b0, "R4");
    expect_out(1'b1, 8'h3B, 2'd2, 2'd0, "R4");
    step(16'h1001, 16'hFFFF, 10'h081, 1'b0, 1'b0, "R3");
    expect_out(1'b1, 8'h03, 2'd3, 2'd0, "R3");
    step(16'h1000, 16'hFFFF, 10'h080, 1'b0, 1'b0, "R7");
    expect_out(1'b1, 8'h3B, 2'd2, 2'd0, "R7");

    step(16'h1000, 16'hFFFF, 10'h080, 1'b1, 1'b0, "R9");
    expect_out(1'b0, 8'h00, 2'd0, 2'd2, "R9");
    step(16'h1000, 16'hFFFF, 10'h080, 1'b0, 1'b0, "R8");
    expect_out(1'b0, 8'h00, 2'd0, 2'd2, "R8");
    step(16'h1001, 16'hFFFF, 10'h081, 1'b0, 1'b0, "R8");
    expect_out(1'b1, 8'h03, 2'd3, 2'd2, "R8");
    step(16'h1001, 16'hFFFF, 10'h081, 1'b1, 1'b0, "R9");
    expect_out(1'b0, 8'h00, 2'd0, 2'd3, "R9");
    step(16'h0000, 16'hFFFF, 10'h000, 1'b0, 1'b1, "R10");
    expect_out(1'b0, 8'h00, 2'd0, 2'd2, "R10");
    step(16'h0000, 16'hFFFF, 10'h000, 1'b0, 1'b1, "R10");
    expect_out(1'b0, 8'h00, 2'd0, 2'd0, "R10");
    step(16'h0000, 16'hFFFF, 10'h000, 1'b0, 1'b1, "R10");
    expect_out(1'b0, 8'h00, 2'd0, 2'd0, "R10");
    step(16'h0000, 16'hFFFF, 10'h000, 1'b1, 1'b0, "R11");
    expect_out(1'b0, 8'h00, 2'd0, 2'd0, "R11");

    step(16'h0800, 16'hFFFF, 10'h000, 1'b0, 1'b0, "R12");
    expect_out(1'b1, 8'h33, 2'd1, 2'd0, "R12");
    step(16'h0800, 16'hFFFF, 10'h000, 1'b1, 1'b0, "R12");
    expect_out(1'b0, 8'h00, 2'd0, 2'd1, "R12");
    step(16'h1000, 16'hFFFF, 10'h080, 1'b0, 1'b0, "R12");
    expect_out(1'b1, 8'h3B, 2'd2, 2'd1, "R12");
    step(16'h1000, 16'hFFFF, 10'h080, 1'b1, 1'b1, "R12");
    expect_out(1'b0, 8'h00, 2'd0, 2'd2, "R12");
    step(16'h0000, 16'hFFFF, 10'h000, 1'b0, 1'b1, "R12");
    expect_out(1'b0, 8'h00, 2'd0, 2'd0, "R12");

    for (int i = 0; i < 800; i++) begin
      step(16'($urandom & $urandom & $urandom), 16'($urandom | $urandom), 10'($urandom),
           ($urandom % 10) < 3, ($urandom % 10) < 2, "R2/R4/R5/R8/R9/R10");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule